// File: doc/BRIEF.md
# Frame DMA Channel Arbiter

This block decides which frame-DMA channels may move data through two CPU ports. There are eight channels. Channels 0 to 5 inject frames, and each has a select bit that assigns it to one of the two CPU ports. Channel 6 always extracts on port 0 and channel 7 always extracts on port 1.

For every port and direction the block keeps one owner. An owner holds the port until it signals the end of its frame, and only then is the port arbitrated again. The current owners then compete for one service slot per cycle toward the shared memory interface. Extraction owners come before injection owners. When both ports have a pending owner of the winning class, the slot alternates between the ports. A port with nothing pending is skipped.

The block has no data path and does not process descriptors. It only resolves ownership and the order of service.

Top module: `fdma_chan_arbiter`

## Requirements
- R1: After reset all grant outputs are 0, `svc_valid` is 0, and the alternation pointer selects port 0. The first time both ports contend for the slot, port 0 is served.
- R2: Injection channel i with `inj_port_sel[i]`=0 can appear only in `inj_gnt_p0[i]`, and with `inj_port_sel[i]`=1 only in `inj_gnt_p1[i]`. Channel 6 is granted through `ext_gnt[0]` and channel 7 through `ext_gnt[1]`.
- R3: A free port grants only a channel whose `ch_en` and `ch_req` are both 1. Among the eligible injection channels mapped to the same port, the highest channel index wins.
- R4: While an owner has not asserted its `ch_eof`, its grant does not change, whatever the other channels do.
- R5: Clearing `ch_en` of an owner in the middle of a frame does not remove its grant. After its `ch_eof`, that channel is not granted again until `ch_en` returns to 1.
- R6: Each injection grant vector is one-hot or zero. No channel is granted on both ports at once. If a port-select bit changes during a frame, the channel stays on its old port until `ch_eof`.
- R7: `svc_valid` is 1 when at least one granted channel has `ch_req` high. If any such owner is an extraction channel, the slot goes to an extraction channel. `svc_chan` is the index of the served channel (6 or 7 for extraction) and `svc_port` is its port.
- R8: When both ports have a pending owner in the winning class, `svc_port` alternates from cycle to cycle. When only one port has a pending owner, that port is served in the same cycle. After every served slot the pointer moves to the other port.
- R9: A grant is registered. When the owner's `ch_eof` is sampled at a clock edge, the grant after that edge already shows the next winner, with no idle cycle. The ending channel may win again if it is still eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 8 | Per-channel enable |
| ch_req | input | 8 | Per-channel request / data pending |
| ch_eof | input | 8 | Per-channel end-of-frame, effective only for the owner |
| inj_port_sel | input | 6 | Port select for injection channels (0: port 0, 1: port 1) |
| inj_gnt_p0 | output | 6 | One-hot injection owner of port 0 |
| inj_gnt_p1 | output | 6 | One-hot injection owner of port 1 |
| ext_gnt | output | 2 | Extraction owner flag per port (bit p = channel 6+p) |
| svc_valid | output | 1 | A service slot is issued this cycle |
| svc_port | output | 1 | Port of the served channel |
| svc_chan | output | 3 | Index of the served channel |

## Verification
The collision that matters most is an end-of-frame that releases one port in the same cycle that the outgoing owner's port-select bit moves it to the other port. In that cycle one port re-arbitrates while the other must still see the channel as owned. Directed steps drive exactly this overlap and expect both ports empty for one edge, then the new port granted. Random runs flip select bits during frames while end-of-frame pulses are frequent, so the overlap also occurs at random. Each cycle is compared against a bench reference model of ownership and slot alternation.

// File: rtl/fdma_arb_pkg.sv
package fdma_arb_pkg;

    localparam int NUM_PORT = 2;

    // Which class of owner wins the service slot in a cycle
    typedef enum logic {
        DIR_INJ = 1'b0,
        DIR_EXT = 1'b1
    } dir_e;

    // One service slot toward the memory interface
    typedef struct packed {
        logic valid;
        logic port;
        dir_e dir;
    } slot_t;

    // Two-port choice: if both pending use the pointer, otherwise the one that is pending
    function automatic logic pick_port(logic [1:0] pend, logic ptr);
        logic r;
        if (pend == 2'b11) r = ptr;
        else               r = pend[1];
        return r;
    endfunction

endpackage

// File: rtl/fdma_owner_lock.sv
module fdma_owner_lock #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig,
    input  logic [N-1:0] eof,
    output logic [N-1:0] gnt
);

    logic         holding;
    logic [N-1:0] pick;
    logic [N-1:0] gnt_nxt;

    // Owner keeps the port until its own end-of-frame
    assign holding = (|gnt) && !(|(gnt & eof));

    // Highest eligible index wins a free port
    always_comb begin
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    assign gnt_nxt = holding ? gnt : pick;

    always_ff @(posedge clk) begin
        if (rst) gnt <= '0;
        else     gnt <= gnt_nxt;
    end

    // R6: grant is one-hot or empty
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R4: an owner without end-of-frame keeps its grant
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        holding |=> (gnt == $past(gnt)));

    // R3: a newly taken grant belongs to a channel that was eligible
    a_r3_elig: assert property (@(posedge clk) disable iff (rst)
        !holding |=> ((gnt & ~$past(elig)) == '0));

    // R1: reset clears the grant
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (gnt == '0));

endmodule

// File: rtl/fdma_slot_sched.sv
module fdma_slot_sched
    import fdma_arb_pkg::*;
#(
    parameter int NUM_INJ = 6,
    parameter int CH_W    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      ext_act,
    input  logic [1:0]      inj_act,
    input  logic [CH_W-1:0] inj_idx0,
    input  logic [CH_W-1:0] inj_idx1,
    output logic            svc_valid,
    output logic            svc_port,
    output logic [CH_W-1:0] svc_chan
);

    logic       ptr;
    logic [1:0] act;
    slot_t      slot;

    always_comb begin
        slot.dir   = (|ext_act) ? DIR_EXT : DIR_INJ;
        act        = (slot.dir == DIR_EXT) ? ext_act : inj_act;
        slot.valid = |act;
        slot.port  = pick_port(act, ptr);
    end

    always_comb begin
        if (slot.dir == DIR_EXT)
            svc_chan = CH_W'(NUM_INJ) + CH_W'(slot.port);
        else
            svc_chan = slot.port ? inj_idx1 : inj_idx0;
    end

    assign svc_valid = slot.valid;
    assign svc_port  = slot.port;

    // Pointer moves away from the port just served
    always_ff @(posedge clk) begin
        if (rst)             ptr <= 1'b0;
        else if (slot.valid) ptr <= ~slot.port;
    end

    // R7: a pending extraction owner always takes the slot
    a_r7_ext_first: assert property (@(posedge clk) disable iff (rst)
        (|ext_act) |-> (svc_valid && (svc_chan >= CH_W'(NUM_INJ))));

    // R8: with both ports pending in the same class on consecutive cycles, the port alternates
    a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
        ((act == 2'b11) && ($past(act) == 2'b11) && ($past(slot.dir) == slot.dir))
        |-> (slot.port != $past(slot.port)));

endmodule

// File: rtl/fdma_chan_arbiter.sv
module fdma_chan_arbiter
    import fdma_arb_pkg::*;
#(
    parameter int NUM_INJ = 6,
    localparam int NUM_CH = NUM_INJ + NUM_PORT,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_eof,
    input  logic [NUM_INJ-1:0] inj_port_sel,
    output logic [NUM_INJ-1:0] inj_gnt_p0,
    output logic [NUM_INJ-1:0] inj_gnt_p1,
    output logic [1:0]        ext_gnt,
    output logic              svc_valid,
    output logic              svc_port,
    output logic [CH_W-1:0]   svc_chan
);

    logic [NUM_INJ-1:0] inj_en, inj_req, inj_eof;
    logic [NUM_INJ-1:0] inj_gnt  [NUM_PORT];
    logic [NUM_INJ-1:0] inj_elig [NUM_PORT];
    logic [CH_W-1:0]    inj_idx  [NUM_PORT];
    logic [1:0]         inj_act;
    logic [1:0]         ext_act;

    assign inj_en  = ch_en[NUM_INJ-1:0];
    assign inj_req = ch_req[NUM_INJ-1:0];
    assign inj_eof = ch_eof[NUM_INJ-1:0];

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        // Eligible: enabled, requesting, mapped here, not owned by the other port
        if (p == 0) begin : g_sel0
            assign inj_elig[p] = inj_en & inj_req & ~inj_port_sel & ~inj_gnt[1];
        end else begin : g_sel1
            assign inj_elig[p] = inj_en & inj_req & inj_port_sel & ~inj_gnt[0];
        end

        fdma_owner_lock #(.N(NUM_INJ)) u_inj_lock (
            .clk  (clk),
            .rst  (rst),
            .elig (inj_elig[p]),
            .eof  (inj_eof),
            .gnt  (inj_gnt[p])
        );

        fdma_owner_lock #(.N(1)) u_ext_lock (
            .clk  (clk),
            .rst  (rst),
            .elig (ch_en[NUM_INJ+p] & ch_req[NUM_INJ+p]),
            .eof  (ch_eof[NUM_INJ+p]),
            .gnt  (ext_gnt[p])
        );

        always_comb begin
            inj_idx[p] = '0;
            for (int i = 0; i < NUM_INJ; i++) begin
                if (inj_gnt[p][i]) inj_idx[p] = CH_W'(i);
            end
        end

        assign inj_act[p] = |(inj_gnt[p] & inj_req);
        assign ext_act[p] = ext_gnt[p] & ch_req[NUM_INJ+p];
    end

    assign inj_gnt_p0 = inj_gnt[0];
    assign inj_gnt_p1 = inj_gnt[1];

    fdma_slot_sched #(.NUM_INJ(NUM_INJ), .CH_W(CH_W)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .ext_act   (ext_act),
        .inj_act   (inj_act),
        .inj_idx0  (inj_idx[0]),
        .inj_idx1  (inj_idx[1]),
        .svc_valid (svc_valid),
        .svc_port  (svc_port),
        .svc_chan  (svc_chan)
    );

    // R6: no injection channel owns both ports
    a_r6_disjoint: assert property (@(posedge clk) disable iff (rst)
        ((inj_gnt_p0 & inj_gnt_p1) == '0));

    for (genvar i = 0; i < NUM_INJ; i++) begin : g_map_chk
        // R2: a new grant appears on the port selected in the previous cycle
        a_r2_map_p0: assert property (@(posedge clk) disable iff (rst)
            $rose(inj_gnt_p0[i]) |-> !$past(inj_port_sel[i]));
        a_r2_map_p1: assert property (@(posedge clk) disable iff (rst)
            $rose(inj_gnt_p1[i]) |-> $past(inj_port_sel[i]));
        // R5: an owner with enable cleared keeps its grant unless it ended its frame
        a_r5_keep_p0: assert property (@(posedge clk) disable iff (rst)
            (inj_gnt_p0[i] && !inj_en[i] && !inj_eof[i]) |=> inj_gnt_p0[i]);
    end

endmodule

// File: tb/tb_fdma_chan_arbiter.sv
`timescale 1ns/1ps
module tb_fdma_chan_arbiter;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ch_en = '0, ch_req = '0, ch_eof = '0;
    logic [5:0] inj_port_sel = '0;
    logic [5:0] inj_gnt_p0, inj_gnt_p1;
    logic [1:0] ext_gnt;
    logic       svc_valid, svc_port;
    logic [2:0] svc_chan;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    int m_inj [2];
    bit m_ext [2];
    bit m_ptr;

    always #(CLK_NS/2) clk = ~clk;

    fdma_chan_arbiter dut (
        .clk(clk), .rst(rst), .ch_en(ch_en), .ch_req(ch_req), .ch_eof(ch_eof),
        .inj_port_sel(inj_port_sel), .inj_gnt_p0(inj_gnt_p0), .inj_gnt_p1(inj_gnt_p1),
        .ext_gnt(ext_gnt), .svc_valid(svc_valid), .svc_port(svc_port), .svc_chan(svc_chan)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] vec_of(int idx);
        logic [5:0] v = '0;
        if (idx >= 0) v[idx] = 1'b1;
        return v;
    endfunction

    // Expected slot from model state and present inputs
    function automatic logic [4:0] exp_slot();
        bit ea0, ea1, ia0, ia1, use_ext, a0, a1, valid, port;
        int chan;
        ea0 = m_ext[0] && ch_req[6];
        ea1 = m_ext[1] && ch_req[7];
        ia0 = (m_inj[0] >= 0) && ch_req[m_inj[0] < 0 ? 0 : m_inj[0]];
        ia1 = (m_inj[1] >= 0) && ch_req[m_inj[1] < 0 ? 0 : m_inj[1]];
        use_ext = ea0 || ea1;
        a0 = use_ext ? ea0 : ia0;
        a1 = use_ext ? ea1 : ia1;
        valid = a0 || a1;
        port  = (a0 && a1) ? m_ptr : a1;
        chan  = use_ext ? 6 + int'(port) : m_inj[port];
        if (!valid) chan = 0;
        return {valid, port, 3'(chan)};
    endfunction

    task automatic model_check();
        logic [4:0] s;
        s = exp_slot();
        chk("R3 port0 injection grant", 32'(inj_gnt_p0), 32'(vec_of(m_inj[0])));
        chk("R2 port1 injection grant", 32'(inj_gnt_p1), 32'(vec_of(m_inj[1])));
        chk("R2 extraction grant", 32'(ext_gnt), {30'd0, m_ext[1], m_ext[0]});
        chk("R7 svc_valid", 32'(svc_valid), 32'(s[4]));
        if (s[4]) begin
            chk("R7 svc_chan", 32'(svc_chan), 32'(s[2:0]));
            chk("R8 svc_port", 32'(svc_port), 32'(s[3]));
        end
    endtask

    task automatic model_update();
        int  ni [2];
        bit  ne [2];
        logic [4:0] s;
        if (rst) begin
            m_inj[0] = -1; m_inj[1] = -1; m_ext[0] = 0; m_ext[1] = 0; m_ptr = 0;
            return;
        end
        s = exp_slot();
        for (int p = 0; p < 2; p++) begin
            int own = m_inj[p];
            if (own >= 0 && !ch_eof[own]) ni[p] = own;
            else begin
                ni[p] = -1;
                for (int i = 0; i < 6; i++)
                    if (ch_en[i] && ch_req[i] && (int'(inj_port_sel[i]) == p) && (m_inj[1-p] != i))
                        ni[p] = i;
            end
            ne[p] = (m_ext[p] && !ch_eof[6+p]) ? 1'b1 : (ch_en[6+p] && ch_req[6+p]);
        end
        if (s[4]) m_ptr = ~s[3];
        m_inj[0] = ni[0]; m_inj[1] = ni[1]; m_ext[0] = ne[0]; m_ext[1] = ne[1];
    endtask

    // Inputs are set at the falling edge; one call covers one clock cycle
    task automatic cyc();
        #2;
        if (!rst) model_check();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        @(negedge clk);
        for (int k = 0; k < 3; k++) cyc();
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 port0 grant after reset", 32'(inj_gnt_p0), 0);
        chk("R1 port1 grant after reset", 32'(inj_gnt_p1), 0);
        chk("R1 ext grant after reset", 32'(ext_gnt), 0);
        chk("R1 svc_valid after reset", 32'(svc_valid), 0);
        #1;
        // R1/R8: first contention goes to port 0, then alternates
        ch_en[7:6] = 2'b11; ch_req[7:6] = 2'b11;
        cyc();
        #1;
        chk("R1 first contended slot channel", 32'(svc_chan), 6);
        cyc();
        #1;
        chk("R8 alternated slot channel", 32'(svc_chan), 7);
        ch_eof[7:6] = 2'b11; ch_req[7:6] = 2'b00; ch_en[7:6] = 2'b00;
        cyc();
        ch_eof = '0;
        chk("R4 extraction released after eof", 32'(ext_gnt), 0);
        // R3: highest eligible index on port 0
        ch_en[1] = 1; ch_en[3] = 1; ch_en[4] = 1;
        ch_req[1] = 1; ch_req[3] = 1; ch_req[4] = 1;
        cyc();
        chk("R3 highest index wins", 32'(inj_gnt_p0), 32'h10);
        // R4: a higher request is ignored while the owner holds
        ch_en[5] = 1; ch_req[5] = 1;
        cyc();
        chk("R4 owner kept", 32'(inj_gnt_p0), 32'h10);
        ch_eof[4] = 1;
        cyc();
        ch_eof = '0;
        chk("R9 next owner without idle cycle", 32'(inj_gnt_p0), 32'h20);
        // R5: enable cleared mid-frame
        ch_en[5] = 0;
        cyc();
        chk("R5 owner kept after enable cleared", 32'(inj_gnt_p0), 32'h20);
        ch_eof[5] = 1;
        cyc();
        ch_eof = '0;
        chk("R5 disabled channel not regranted", 32'(inj_gnt_p0), 32'h10);
        cyc();
        chk("R5 disabled channel still not granted", 32'(inj_gnt_p0[5]), 0);
        // Clear and move to R6
        ch_en[5:0] = '0; ch_req[5:0] = '0; ch_eof[4] = 1;
        cyc();
        ch_eof = '0;
        chk("R4 port0 empty after eof", 32'(inj_gnt_p0), 0);
        ch_en[2] = 1; ch_req[2] = 1; inj_port_sel[2] = 0;
        cyc();
        chk("R2 channel 2 on port 0", 32'(inj_gnt_p0), 32'h04);
        inj_port_sel[2] = 1;
        cyc();
        chk("R6 stays on old port", 32'(inj_gnt_p0), 32'h04);
        chk("R6 not on new port mid-frame", 32'(inj_gnt_p1), 0);
        ch_eof[2] = 1;
        cyc();
        ch_eof = '0;
        chk("R6 port0 free after eof", 32'(inj_gnt_p0), 0);
        chk("R6 port1 waits one edge", 32'(inj_gnt_p1), 0);
        cyc();
        chk("R2 channel 2 now on port 1", 32'(inj_gnt_p1), 32'h04);
        // R7: extraction takes the slot over injection
        ch_en[7] = 1; ch_req[7] = 1;
        cyc();
        #1;
        chk("R7 extraction first", 32'(svc_chan), 7);
        ch_req[7] = 0;
        #1;
        chk("R7 injection served when extraction idle", 32'(svc_chan), 2);
        chk("R8 single pending port served", 32'(svc_port), 1);
        cyc();
        ch_eof = 8'hFF; ch_en = '0; ch_req = '0;
        cyc();
        ch_eof = '0;
        cyc();
        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < 8; c++) begin
                ch_en[c]  = ($urandom % 16) != 0;
                ch_req[c] = ($urandom % 10) < 6;
                ch_eof[c] = ($urandom % 4) == 0;
            end
            for (int c = 0; c < 6; c++)
                if (($urandom % 20) == 0) inj_port_sel[c] = ~inj_port_sel[c];
            cyc();
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule